// File: doc/BRIEF.md
# Masked Latching Interrupt Aggregator

The block gathers sixteen external, level-signalled interrupt lines into a single request line for a host processor. Each line is brought into the clock domain through a two-stage synchronizer. When a synchronized line is high and its enable bit is already set, the matching pending bit is set and stays set. A line that is high while disabled leaves no trace. A line that goes low never clears anything.

Software sees three registers through a simple single-cycle register port. The enable register and the pending register can be read and written. The level register is read-only and shows the synchronized input levels whatever the enables are. A write to the pending register replaces its whole contents, so software clears a bit by writing zero to it. Both writable registers store only the bits of a fixed keep-mask, and all other bits stay at zero. The request output is high while any pending bit is also enabled.

Top module: `irq_aggregator`

## Requirements
- R1: Synchronous reset clears the enable, pending and level registers and drives `irq_out` low.
- R2: A write at offset 0xC0 stores `bus_wdata & 0x000FEEFF` in the enable register, and a read at 0xC0 returns it. Bits 8, 12 and 20 to 31 always read as zero.
- R3: A write at offset 0xD0 replaces the whole pending register with `bus_wdata & 0x000FEEFF`, so writing 0 clears a bit. A read at 0xD0 returns the pending register.
- R4: An input held high while its enable bit is set sets its pending bit at the third rising clock edge after the input changes.
- R5: An input that is high while its enable bit is clear leaves its pending bit unchanged. Enabling the line after it has gone low does not set the pending bit.
- R6: A low input never clears a pending bit. Only a pending-register write or a new latch changes the pending bits.
- R7: `irq_out` is high exactly when (pending AND enable) is nonzero. It follows enable writes, pending writes and latches in the same cycle as the register update, and this includes software-set pending bits 16 to 19.
- R8: A read at offset 0xB0 returns the synchronized input levels (bit i is input i), whatever the enable bits are. It reflects a change at the second rising edge after the input changes.
- R9: A read at any other offset returns zero, and a write to any other offset changes no register.
- R10: When a pending-register write and a latch fall on the same edge, the written value wins. A line that is still enabled and high sets its bit again on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 16 | Asynchronous level interrupt lines |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Request line to the host |

## Verification
The assertions take for granted that reset is held high from time zero for at least two edges. They also assume that `bus_wr` and `bus_addr` are stable around each sampling edge. They assume nothing about `irq_in`, because the synchronizer stages are checked only against each other. The bench drives every port at the falling edge. It holds each input level for at least three edges before it judges a latch, and it samples the read data one time unit after the falling edge, never near a rising edge.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NUM_IN = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEEP = 32'h000F_EEFF,
  parameter logic [ADDR_W-1:0] OFF_LVL  = 8'hB0,
  parameter logic [ADDR_W-1:0] OFF_EN   = 8'hC0,
  parameter logic [ADDR_W-1:0] OFF_PEND = 8'hD0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  localparam int PAD = DATA_W - NUM_IN;

  logic [NUM_IN-1:0] meta_q, lvl_q;
  logic [DATA_W-1:0] en_q, pend_q, hit;
  logic wr_en, wr_pend;

  assign wr_en   = bus_wr && bus_addr == OFF_EN;
  assign wr_pend = bus_wr && bus_addr == OFF_PEND;
  assign hit     = {{PAD{1'b0}}, lvl_q & en_q[NUM_IN-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      lvl_q  <= '0;
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      meta_q <= irq_in;
      lvl_q  <= meta_q;
      if (wr_en)   en_q <= bus_wdata & KEEP;
      if (wr_pend) pend_q <= bus_wdata & KEEP;
      else         pend_q <= pend_q | hit;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFF_LVL:  bus_rdata = {{PAD{1'b0}}, lvl_q};
      OFF_EN:   bus_rdata = en_q;
      OFF_PEND: bus_rdata = pend_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_out = |(pend_q & en_q);
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int NUM_IN = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEEP = 32'h000F_EEFF,
  parameter logic [ADDR_W-1:0] OFF_EN   = 8'hC0,
  parameter logic [ADDR_W-1:0] OFF_PEND = 8'hD0
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NUM_IN-1:0] meta_q,
  input logic [NUM_IN-1:0] lvl_q,
  input logic [DATA_W-1:0] en_q,
  input logic [DATA_W-1:0] pend_q,
  input logic              irq_out
);
  logic w_en, w_pend;
  logic [DATA_W-1:0] ready;
  assign w_en   = bus_wr && bus_addr == OFF_EN;
  assign w_pend = bus_wr && bus_addr == OFF_PEND;
  assign ready  = {{(DATA_W-NUM_IN){1'b0}}, lvl_q & en_q[NUM_IN-1:0]};

  p_en_store_r2: assert property (@(posedge clk) disable iff (rst)
    $past(w_en) |-> en_q == ($past(bus_wdata) & KEEP));

  p_pend_store_r3: assert property (@(posedge clk) disable iff (rst)
    $past(w_pend) |-> pend_q == ($past(bus_wdata) & KEEP));

  p_latch_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(w_pend) |-> (pend_q & $past(ready)) == $past(ready));

  p_no_clear_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(w_pend) |-> (pend_q & $past(pend_q)) == $past(pend_q));

  p_raw_follow_r8: assert property (@(posedge clk) disable iff (rst)
    lvl_q == $past(meta_q));

  p_rise_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> ($past(w_en) || $past(w_pend) || ($past(ready & ~pend_q) != '0)));
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NUM_IN(NUM_IN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEEP(KEEP),
  .OFF_EN(OFF_EN), .OFF_PEND(OFF_PEND)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .meta_q(meta_q), .lvl_q(lvl_q),
  .en_q(en_q), .pend_q(pend_q), .irq_out(irq_out)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_in = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // {offset, write data, expected read back}
  localparam logic [71:0] VEC [9] = '{
    {8'hC0, 32'hFFFF_FFFF, 32'h000F_EEFF},
    {8'hC0, 32'h0000_1100, 32'h0000_0000},
    {8'hC0, 32'h1234_5678, 32'h0004_4678},
    {8'hC0, 32'h0000_0000, 32'h0000_0000},
    {8'hD0, 32'hFFFF_FFFF, 32'h000F_EEFF},
    {8'hD0, 32'h0000_1100, 32'h0000_0000},
    {8'hD0, 32'h000A_5A5A, 32'h000A_4A5A},
    {8'hD0, 32'h0000_0000, 32'h0000_0000},
    {8'hA0, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    wait_n(3);
    rst = 1'b0;
    rd(8'hC0, v); chk("R1 enable", v, 0);
    rd(8'hD0, v); chk("R1 pending", v, 0);
    rd(8'hB0, v); chk("R1 level", v, 0);
    chk("R1 irq_out", {31'b0, irq_out}, 0);

    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      chk(VEC[i][71:64] == 8'hC0 ? "R2 keep-mask" :
          VEC[i][71:64] == 8'hD0 ? "R3 keep-mask" : "R9 unmapped read", v, VEC[i][31:0]);
    end

    wr(8'hC0, 32'h0000_00F0);
    wr(8'hE4, 32'hFFFF_FFFF);
    rd(8'hC0, v); chk("R9 write ignored enable", v, 32'hF0);
    rd(8'hD0, v); chk("R9 write ignored pending", v, 0);
    wr(8'hC0, 0);

    // disabled high line leaves no trace
    irq_in = 16'h0001;
    wait_n(4);
    rd(8'hD0, v); chk("R5 disabled no latch", v, 0);
    rd(8'hB0, v); chk("R8 level while disabled", v, 32'h1);
    irq_in = 16'h0000;
    wait_n(3);
    wr(8'hC0, 32'h1);
    wait_n(3);
    rd(8'hD0, v); chk("R5 nothing remembered", v, 0);
    chk("R5 irq_out", {31'b0, irq_out}, 0);

    // enabled latch timing
    wr(8'hC0, 32'h2);
    irq_in = 16'h0002;
    wait_n(2);
    rd(8'hB0, v); chk("R8 level at edge 2", v, 32'h2);
    rd(8'hD0, v); chk("R4 not yet at edge 2", v, 0);
    wait_n(1);
    rd(8'hD0, v); chk("R4 latched at edge 3", v, 32'h2);
    chk("R7 irq_out raised", {31'b0, irq_out}, 1);

    irq_in = 16'h0000;
    wait_n(4);
    rd(8'hD0, v); chk("R6 low keeps pending", v, 32'h2);
    rd(8'hB0, v); chk("R8 level fell", v, 0);

    wr(8'hC0, 0);
    chk("R7 masked off", {31'b0, irq_out}, 0);
    rd(8'hD0, v); chk("R7 pending kept under mask", v, 32'h2);
    wr(8'hC0, 32'h2);
    chk("R7 unmasked", {31'b0, irq_out}, 1);
    wr(8'hD0, 0);
    chk("R3 clear by zero", {31'b0, irq_out}, 0);

    // write beats latch, then re-latch
    wr(8'hC0, 32'h4);
    irq_in = 16'h0004;
    wait_n(3);
    rd(8'hD0, v); chk("R10 latched before write", v, 32'h4);
    wr(8'hD0, 0);
    rd(8'hD0, v); chk("R10 write wins", v, 0);
    wait_n(1);
    rd(8'hD0, v); chk("R10 relatch next edge", v, 32'h4);
    irq_in = 16'h0000;
    wr(8'hD0, 0);

    // bit 8 can never be enabled
    wr(8'hC0, 32'hFFFF_FFFF);
    irq_in = 16'h0100;
    wait_n(4);
    rd(8'hD0, v); chk("R2 bit 8 never latches", v, 0);
    rd(8'hB0, v); chk("R8 bit 8 level", v, 32'h100);
    irq_in = 16'h0000;

    // software-set upper pending bit
    wr(8'hC0, 32'h0001_0000);
    wr(8'hD0, 32'h0001_0000);
    chk("R7 software bit 16", {31'b0, irq_out}, 1);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(8'hD0, v); chk("R1 pending after reset", v, 0);
    chk("R1 irq_out after reset", {31'b0, irq_out}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule